// File: doc/BRIEF.md
# Load-Group Instruction Byte Decoder

This block sits behind an instruction fetch stream and takes one byte in each cycle where the valid input is high. It recognizes the 8-bit data-move instructions of a classic 8-bit CPU that has two index registers. It collects any prefix byte, the opcode, a signed displacement, an immediate byte or a 16-bit direct address. It then emits one decoded record together with a one-cycle completion pulse. The record gives the kind of each operand, the register codes, the captured displacement, immediate and address, the instruction length in bytes, the clock-state count and a flag-update selector.

Any byte sequence that is not a member of the load group raises a one-cycle illegal pulse instead, and the decoder returns to its idle state. Moving the data, driving the memory bus and all other instruction groups are left to neighbouring logic. The asynchronous reset is released through a short synchronizer. The record registers keep their value until the next completed instruction.

Top module: `ldg_decoder`

## Requirements
- R1: After reset, `done_o`, `illegal_o` and every record field are zero. Operand kind codes are: register=0, memory via HL=1, via BC=2, via DE=3, IX+d=4, IY+d=5, direct address=6, immediate=7, I=8, R=9. Register codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7, and 0 is used for any operand that is not a register.
- R2: A single byte 01 ddd sss, with neither field equal to 110, decodes as register-to-register: 1 byte, 4 states.
- R3: 00 ddd 110 followed by n loads immediate n: 2 bytes. It takes 7 states to a register, and 10 states when ddd=110 (memory via HL).
- R4: Field code 110 in 01 ddd sss selects memory via HL: 1 byte, 7 states, in either direction.
- R5: A prefix of 0xDD (IX) or 0xFD (IY), then 01 ddd 110 or 01 110 sss, then displacement d, gives an indexed load or store: 3 bytes, 19 states, with `disp_o` = d.
- R6: Prefix, 0x36, d, n stores an immediate to an indexed location. The displacement comes before the immediate: 4 bytes, 19 states.
- R7: Opcodes 0x0A/0x1A load A via BC/DE, and 0x02/0x12 store A via BC/DE: 1 byte, 7 states each.
- R8: Opcode 0x3A loads A from a direct address and 0x32 stores A to it. The address arrives low byte first: 3 bytes, 13 states.
- R9: After a 0xED prefix, 0x57 is A←I, 0x5F is A←R, 0x47 is I←A and 0x4F is R←A: 2 bytes, IR_STATES states.
- R10: `flag_upd_o` is 1 only for A←I and A←R, and is 0 for every other load.
- R11: An opcode outside the group gives one `illegal_o` pulse and no `done_o`, and the next byte is decoded as a fresh instruction. This covers unprefixed 0x76, 01 110 110 under an index prefix, any other opcode after a prefix, and a second prefix.
- R12: A cycle with `byte_valid_i` low is ignored. Gaps may fall between any two bytes of an instruction without changing the result.
- R13: `done_o` and `illegal_o` appear one cycle after the final byte and are never high together. The record holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Instruction byte |
| done_o | output | 1 | Record complete pulse |
| illegal_o | output | 1 | Unrecognized sequence pulse |
| dst_kind_o | output | 4 | Destination operand kind |
| src_kind_o | output | 4 | Source operand kind |
| dst_reg_o | output | 3 | Destination register code |
| src_reg_o | output | 3 | Source register code |
| disp_o | output | 8 | Signed displacement |
| imm_o | output | 8 | Immediate byte |
| addr_o | output | 16 | Direct address |
| nbytes_o | output | 3 | Instruction length |
| tstates_o | output | 5 | Clock-state count |
| flag_upd_o | output | 1 | Flags follow the I/R copy |

## Verification
The bench builds the block with its defaults: IR_STATES=9 and SYNC_STAGES=2. With these values the I/R transfer count can be checked as a definite number of states. The reset release reaches the decoder two cycles after `rst_n` rises. The scoreboard runs every encoding form back to back, and also with idle gaps of garbage bytes between bytes. This exercises the prefix and displacement sequencing, the recovery after an illegal opcode, and record holding.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int TS_W   = 5;
  localparam int RC_W   = 3;
  localparam int NB_W   = 3;

  localparam logic [BYTE_W-1:0] OP_PFX_IX = 8'hDD;
  localparam logic [BYTE_W-1:0] OP_PFX_IY = 8'hFD;
  localparam logic [BYTE_W-1:0] OP_PFX_ED = 8'hED;

  typedef enum logic [3:0] {
    K_REG = 4'd0, K_HL = 4'd1, K_BC = 4'd2, K_DE = 4'd3, K_IX = 4'd4,
    K_IY = 4'd5, K_DIR = 4'd6, K_IMM = 4'd7, K_I = 4'd8, K_R = 4'd9
  } kind_e;

  typedef enum logic [1:0] {CTX_BASE, CTX_IX, CTX_IY, CTX_ED} ctx_e;

  typedef struct packed {
    logic            legal;
    logic            pfx;
    ctx_e            pfx_ctx;
    kind_e           dk;
    kind_e           sk;
    logic [RC_W-1:0] dr;
    logic [RC_W-1:0] sr;
    logic            need_disp;
    logic            need_imm;
    logic            need_addr;
    logic [TS_W-1:0] ts;
    logic            fl;
  } plan_t;

  typedef struct packed {
    kind_e             dk;
    kind_e             sk;
    logic [RC_W-1:0]   dr;
    logic [RC_W-1:0]   sr;
    logic [BYTE_W-1:0] disp;
    logic [BYTE_W-1:0] imm;
    logic [ADDR_W-1:0] addr;
    logic [NB_W-1:0]   nb;
    logic [TS_W-1:0]   ts;
    logic              fl;
  } rec_t;
endpackage

// File: rtl/ldg_classify.sv
module ldg_classify
  import ldg_pkg::*;
#(
  parameter int IR_STATES = 9
) (
  input  ctx_e              ctx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output plan_t             plan_o
);
  localparam logic [TS_W-1:0] TS_RR  = TS_W'(4);
  localparam logic [TS_W-1:0] TS_MEM = TS_W'(7);
  localparam logic [TS_W-1:0] TS_HLN = TS_W'(10);
  localparam logic [TS_W-1:0] TS_DIR = TS_W'(13);
  localparam logic [TS_W-1:0] TS_IDX = TS_W'(19);
  localparam logic [TS_W-1:0] TS_IR  = TS_W'(IR_STATES);
  localparam logic [RC_W-1:0] RC_MEM = 3'b110;
  localparam logic [RC_W-1:0] RC_A   = 3'b111;

  logic [RC_W-1:0] fd, fs;
  logic            is_mov, is_ldi;
  kind_e           idx_k;

  assign fd     = byte_i[5:3];
  assign fs     = byte_i[2:0];
  assign is_mov = (byte_i[7:6] == 2'b01);
  assign is_ldi = (byte_i[7:6] == 2'b00) && (fs == RC_MEM);
  assign idx_k  = (ctx_i == CTX_IY) ? K_IY : K_IX;

  always_comb begin
    plan_o = '0;
    unique case (ctx_i)
      CTX_BASE: begin
        if (byte_i == OP_PFX_IX || byte_i == OP_PFX_IY || byte_i == OP_PFX_ED) begin
          plan_o.legal   = 1'b1;
          plan_o.pfx     = 1'b1;
          plan_o.pfx_ctx = (byte_i == OP_PFX_IX) ? CTX_IX :
                           (byte_i == OP_PFX_IY) ? CTX_IY : CTX_ED;
        end else if (is_mov && !(fd == RC_MEM && fs == RC_MEM)) begin
          plan_o.legal = 1'b1;
          plan_o.dk    = (fd == RC_MEM) ? K_HL : K_REG;
          plan_o.dr    = (fd == RC_MEM) ? '0 : fd;
          plan_o.sk    = (fs == RC_MEM) ? K_HL : K_REG;
          plan_o.sr    = (fs == RC_MEM) ? '0 : fs;
          plan_o.ts    = (fd == RC_MEM || fs == RC_MEM) ? TS_MEM : TS_RR;
        end else if (is_ldi) begin
          plan_o.legal    = 1'b1;
          plan_o.need_imm = 1'b1;
          plan_o.dk       = (fd == RC_MEM) ? K_HL : K_REG;
          plan_o.dr       = (fd == RC_MEM) ? '0 : fd;
          plan_o.sk       = K_IMM;
          plan_o.ts       = (fd == RC_MEM) ? TS_HLN : TS_MEM;
        end else begin
          unique case (byte_i)
            8'h0A, 8'h1A: begin
              plan_o.legal = 1'b1;
              plan_o.dk = K_REG; plan_o.dr = RC_A;
              plan_o.sk = byte_i[4] ? K_DE : K_BC;
              plan_o.ts = TS_MEM;
            end
            8'h02, 8'h12: begin
              plan_o.legal = 1'b1;
              plan_o.dk = byte_i[4] ? K_DE : K_BC;
              plan_o.sk = K_REG; plan_o.sr = RC_A;
              plan_o.ts = TS_MEM;
            end
            8'h3A: begin
              plan_o.legal = 1'b1; plan_o.need_addr = 1'b1;
              plan_o.dk = K_REG; plan_o.dr = RC_A; plan_o.sk = K_DIR;
              plan_o.ts = TS_DIR;
            end
            8'h32: begin
              plan_o.legal = 1'b1; plan_o.need_addr = 1'b1;
              plan_o.dk = K_DIR; plan_o.sk = K_REG; plan_o.sr = RC_A;
              plan_o.ts = TS_DIR;
            end
            default: plan_o.legal = 1'b0;
          endcase
        end
      end
      CTX_IX, CTX_IY: begin
        if (is_mov && fd == RC_MEM && fs != RC_MEM) begin
          plan_o.legal = 1'b1; plan_o.need_disp = 1'b1;
          plan_o.dk = idx_k; plan_o.sk = K_REG; plan_o.sr = fs;
          plan_o.ts = TS_IDX;
        end else if (is_mov && fs == RC_MEM && fd != RC_MEM) begin
          plan_o.legal = 1'b1; plan_o.need_disp = 1'b1;
          plan_o.dk = K_REG; plan_o.dr = fd; plan_o.sk = idx_k;
          plan_o.ts = TS_IDX;
        end else if (byte_i == 8'h36) begin
          plan_o.legal = 1'b1; plan_o.need_disp = 1'b1; plan_o.need_imm = 1'b1;
          plan_o.dk = idx_k; plan_o.sk = K_IMM;
          plan_o.ts = TS_IDX;
        end
      end
      CTX_ED: begin
        unique case (byte_i)
          8'h57, 8'h5F: begin
            plan_o.legal = 1'b1; plan_o.fl = 1'b1;
            plan_o.dk = K_REG; plan_o.dr = RC_A;
            plan_o.sk = byte_i[3] ? K_R : K_I;
            plan_o.ts = TS_IR;
          end
          8'h47, 8'h4F: begin
            plan_o.legal = 1'b1;
            plan_o.dk = byte_i[3] ? K_R : K_I;
            plan_o.sk = K_REG; plan_o.sr = RC_A;
            plan_o.ts = TS_IR;
          end
          default: plan_o.legal = 1'b0;
        endcase
      end
      default: plan_o = '0;
    endcase
  end
endmodule

// File: rtl/ldg_seq.sv
module ldg_seq
  import ldg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  plan_t             plan_i,
  output ctx_e              ctx_o,
  output logic              fin_o,
  output logic              ill_o,
  output rec_t              rec_o
);
  typedef enum logic [2:0] {S_IDLE, S_PFX, S_DISP, S_IMM, S_ALO, S_AHI} st_e;

  st_e               state_q, state_d;
  ctx_e              ctx_q, ctx_d;
  plan_t             plan_q, plan_d;
  logic [BYTE_W-1:0] disp_q, disp_d, imm_q, imm_d, lo_q, lo_d;
  logic [NB_W-1:0]   nb_q, nb_d;
  logic              use_new;
  plan_t             pl;

  assign ctx_o = (state_q == S_PFX) ? ctx_q : CTX_BASE;

  always_comb begin
    state_d = state_q; ctx_d = ctx_q; plan_d = plan_q;
    disp_d = disp_q; imm_d = imm_q; lo_d = lo_q; nb_d = nb_q;
    fin_o = 1'b0; ill_o = 1'b0; use_new = 1'b0;
    if (vld_i) begin
      unique case (state_q)
        S_IDLE, S_PFX: begin
          nb_d    = (state_q == S_IDLE) ? NB_W'(1) : nb_q + NB_W'(1);
          disp_d  = '0; imm_d = '0; lo_d = '0;
          use_new = 1'b1;
          if (!plan_i.legal) begin
            ill_o = 1'b1; state_d = S_IDLE; ctx_d = CTX_BASE;
          end else if (plan_i.pfx) begin
            state_d = S_PFX; ctx_d = plan_i.pfx_ctx;
          end else begin
            plan_d = plan_i; ctx_d = CTX_BASE;
            if (plan_i.need_disp)      state_d = S_DISP;
            else if (plan_i.need_imm)  state_d = S_IMM;
            else if (plan_i.need_addr) state_d = S_ALO;
            else begin fin_o = 1'b1; state_d = S_IDLE; end
          end
        end
        S_DISP: begin
          disp_d = byte_i; nb_d = nb_q + NB_W'(1);
          if (plan_q.need_imm) state_d = S_IMM;
          else begin fin_o = 1'b1; state_d = S_IDLE; end
        end
        S_IMM: begin
          imm_d = byte_i; nb_d = nb_q + NB_W'(1);
          fin_o = 1'b1; state_d = S_IDLE;
        end
        S_ALO: begin
          lo_d = byte_i; nb_d = nb_q + NB_W'(1); state_d = S_AHI;
        end
        S_AHI: begin
          nb_d = nb_q + NB_W'(1); fin_o = 1'b1; state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_comb begin
    pl         = use_new ? plan_i : plan_q;
    rec_o.dk   = pl.dk;
    rec_o.sk   = pl.sk;
    rec_o.dr   = pl.dr;
    rec_o.sr   = pl.sr;
    rec_o.ts   = pl.ts;
    rec_o.fl   = pl.fl;
    rec_o.disp = disp_d;
    rec_o.imm  = imm_d;
    rec_o.addr = (state_q == S_AHI) ? {byte_i, lo_q} : '0;
    rec_o.nb   = nb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; ctx_q <= CTX_BASE; plan_q <= '0;
      disp_q <= '0; imm_q <= '0; lo_q <= '0; nb_q <= '0;
    end else if (vld_i) begin
      state_q <= state_d; ctx_q <= ctx_d; plan_q <= plan_d;
      disp_q <= disp_d; imm_q <= imm_d; lo_q <= lo_d; nb_q <= nb_d;
    end
  end

  p_gap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(state_q) && $stable(nb_q) && $stable(disp_q));
  p_ill_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ill_o |=> state_q == S_IDLE && ctx_o == CTX_BASE);
  p_disp_plan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_DISP |-> plan_q.legal && !plan_q.pfx && plan_q.need_disp &&
                          plan_q.pfx_ctx == CTX_BASE);
  p_addr_plan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_ALO |-> plan_q.need_addr);
endmodule

// File: rtl/ldg_decoder.sv
module ldg_decoder
  import ldg_pkg::*;
#(
  parameter int IR_STATES   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [3:0]        dst_kind_o,
  output logic [3:0]        src_kind_o,
  output logic [RC_W-1:0]   dst_reg_o,
  output logic [RC_W-1:0]   src_reg_o,
  output logic [BYTE_W-1:0] disp_o,
  output logic [BYTE_W-1:0] imm_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [NB_W-1:0]   nbytes_o,
  output logic [TS_W-1:0]   tstates_o,
  output logic              flag_upd_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic  srst_n;
  ctx_e  ctx;
  plan_t plan;
  logic  fin, ill;
  rec_t  rec_d, rec_q;
  logic  done_q, ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_STAGES-1];

  ldg_classify #(.IR_STATES(IR_STATES)) u_cls (
    .ctx_i(ctx), .byte_i(byte_i), .plan_o(plan)
  );

  ldg_seq u_seq (
    .clk(clk), .rst_n(srst_n), .vld_i(byte_valid_i), .byte_i(byte_i),
    .plan_i(plan), .ctx_o(ctx), .fin_o(fin), .ill_o(ill), .rec_o(rec_d)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_q <= 1'b0; ill_q <= 1'b0; rec_q <= '0;
    end else begin
      done_q <= fin;
      ill_q  <= ill;
      if (fin) rec_q <= rec_d;
    end
  end

  assign done_o     = done_q;
  assign illegal_o  = ill_q;
  assign dst_kind_o = rec_q.dk;
  assign src_kind_o = rec_q.sk;
  assign dst_reg_o  = rec_q.dr;
  assign src_reg_o  = rec_q.sr;
  assign disp_o     = rec_q.disp;
  assign imm_o      = rec_q.imm;
  assign addr_o     = rec_q.addr;
  assign nbytes_o   = rec_q.nb;
  assign tstates_o  = rec_q.ts;
  assign flag_upd_o = rec_q.fl;

  p_mutex_r13: assert property (@(posedge clk) disable iff (!srst_n)
    !(done_o && illegal_o));
  p_done_byte_r12: assert property (@(posedge clk) disable iff (!srst_n)
    done_o |-> $past(byte_valid_i));
  p_ir_flags_r10: assert property (@(posedge clk) disable iff (!srst_n)
    done_o && flag_upd_o |-> (rec_q.sk == K_I || rec_q.sk == K_R) &&
                             rec_q.dk == K_REG && nbytes_o == NB_W'(2));
  p_idx_len_r5: assert property (@(posedge clk) disable iff (!srst_n)
    done_o && (rec_q.dk inside {K_IX, K_IY} || rec_q.sk inside {K_IX, K_IY})
      |-> tstates_o == TS_W'(19) && nbytes_o >= NB_W'(3));
  p_dir_len_r8: assert property (@(posedge clk) disable iff (!srst_n)
    done_o && (rec_q.dk == K_DIR || rec_q.sk == K_DIR)
      |-> tstates_o == TS_W'(13) && nbytes_o == NB_W'(3));
endmodule

// File: tb/ldg_decoder_test.sv
module ldg_decoder_test;
  import ldg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic done_o, illegal_o, flag_upd_o;
  logic [3:0] dst_kind_o, src_kind_o;
  logic [2:0] dst_reg_o, src_reg_o, nbytes_o;
  logic [7:0] disp_o, imm_o;
  logic [15:0] addr_o;
  logic [4:0] tstates_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  rec_t  exp_q[$];
  bit    ill_q[$];
  string tag_q[$];
  rec_t  last_rec = '0;

  always #2.5 clk = ~clk;

  ldg_decoder uut (
    .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .done_o(done_o), .illegal_o(illegal_o), .dst_kind_o(dst_kind_o),
    .src_kind_o(src_kind_o), .dst_reg_o(dst_reg_o), .src_reg_o(src_reg_o),
    .disp_o(disp_o), .imm_o(imm_o), .addr_o(addr_o), .nbytes_o(nbytes_o),
    .tstates_o(tstates_o), .flag_upd_o(flag_upd_o)
  );

  function automatic rec_t mk(kind_e dk, kind_e sk, logic [2:0] dr, logic [2:0] sr,
                              logic [7:0] d, logic [7:0] n, logic [15:0] a,
                              logic [2:0] nb, logic [4:0] ts, logic fl);
    rec_t r;
    r.dk = dk; r.sk = sk; r.dr = dr; r.sr = sr; r.disp = d; r.imm = n;
    r.addr = a; r.nb = nb; r.ts = ts; r.fl = fl;
    return r;
  endfunction

  function automatic rec_t actual();
    return rec_t'({dst_kind_o, src_kind_o, dst_reg_o, src_reg_o, disp_o, imm_o,
                   addr_o, nbytes_o, tstates_o, flag_upd_o});
  endfunction

  task automatic check(string tag, bit ok, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_ok(string tag, rec_t r);
    exp_q.push_back(r); ill_q.push_back(1'b0); tag_q.push_back(tag);
  endtask

  task automatic push_ill(string tag);
    exp_q.push_back('0); ill_q.push_back(1'b1); tag_q.push_back(tag);
  endtask

  task automatic send(logic [7:0] b, int gap);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0; byte_i = 8'h76;
    repeat (gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && (done_o || illegal_o)) begin
      if (done_o && illegal_o) check("R13 both pulses", 1'b0, 64'd3, 64'd1);
      if (exp_q.size() == 0) begin
        check("R11 unexpected output", 1'b0, {62'd0, done_o, illegal_o}, 64'd0);
      end else begin
        automatic rec_t  e   = exp_q.pop_front();
        automatic bit    ei  = ill_q.pop_front();
        automatic string tg  = tag_q.pop_front();
        if (ei) check(tg, illegal_o && !done_o, {62'd0, done_o, illegal_o}, 64'd1);
        else begin
          check(tg, done_o && !illegal_o && actual() == e, 64'(actual()), 64'(e));
          last_rec = e;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reset", !done_o && !illegal_o && actual() == '0, 64'(actual()), 64'd0);

    // R2 register to register
    push_ok("R2 LD B,C", mk(K_REG, K_REG, 3'd0, 3'd1, 0, 0, 0, 3'd1, 5'd4, 0)); send(8'h41, 0);
    push_ok("R2 LD A,A", mk(K_REG, K_REG, 3'd7, 3'd7, 0, 0, 0, 3'd1, 5'd4, 0)); send(8'h7F, 0);
    // R3 immediate
    push_ok("R3 LD E,n", mk(K_REG, K_IMM, 3'd3, 3'd0, 0, 8'h5A, 0, 3'd2, 5'd7, 0));
    send(8'h1E, 0); send(8'h5A, 0);
    push_ok("R3 LD (HL),n", mk(K_HL, K_IMM, 0, 0, 0, 8'hC3, 0, 3'd2, 5'd10, 0));
    send(8'h36, 0); send(8'hC3, 0);
    // R4 via HL
    push_ok("R4 LD H,(HL)", mk(K_REG, K_HL, 3'd4, 0, 0, 0, 0, 3'd1, 5'd7, 0)); send(8'h66, 0);
    push_ok("R4 LD (HL),L", mk(K_HL, K_REG, 0, 3'd5, 0, 0, 0, 3'd1, 5'd7, 0)); send(8'h75, 0);
    // R5 indexed
    push_ok("R5 LD C,(IX+d)", mk(K_REG, K_IX, 3'd1, 0, 8'h05, 0, 0, 3'd3, 5'd19, 0));
    send(8'hDD, 0); send(8'h4E, 0); send(8'h05, 0);
    push_ok("R5 LD (IY+d),A", mk(K_IY, K_REG, 0, 3'd7, 8'hF0, 0, 0, 3'd3, 5'd19, 0));
    send(8'hFD, 0); send(8'h77, 0); send(8'hF0, 0);
    // R6 indexed immediate: displacement then immediate
    push_ok("R6 LD (IX+d),n", mk(K_IX, K_IMM, 0, 0, 8'h80, 8'h99, 0, 3'd4, 5'd19, 0));
    send(8'hDD, 0); send(8'h36, 0); send(8'h80, 0); send(8'h99, 0);
    push_ok("R6 LD (IY+d),n", mk(K_IY, K_IMM, 0, 0, 8'h7F, 8'h00, 0, 3'd4, 5'd19, 0));
    send(8'hFD, 0); send(8'h36, 0); send(8'h7F, 0); send(8'h00, 0);
    // R7 accumulator through pairs
    push_ok("R7 LD A,(BC)", mk(K_REG, K_BC, 3'd7, 0, 0, 0, 0, 3'd1, 5'd7, 0)); send(8'h0A, 0);
    push_ok("R7 LD A,(DE)", mk(K_REG, K_DE, 3'd7, 0, 0, 0, 0, 3'd1, 5'd7, 0)); send(8'h1A, 0);
    push_ok("R7 LD (BC),A", mk(K_BC, K_REG, 0, 3'd7, 0, 0, 0, 3'd1, 5'd7, 0)); send(8'h02, 0);
    push_ok("R7 LD (DE),A", mk(K_DE, K_REG, 0, 3'd7, 0, 0, 0, 3'd1, 5'd7, 0)); send(8'h12, 0);
    // R8 direct address, low byte first
    push_ok("R8 LD A,(nn)", mk(K_REG, K_DIR, 3'd7, 0, 0, 0, 16'h1234, 3'd3, 5'd13, 0));
    send(8'h3A, 0); send(8'h34, 0); send(8'h12, 0);
    push_ok("R8 LD (nn),A", mk(K_DIR, K_REG, 0, 3'd7, 0, 0, 16'hABCD, 3'd3, 5'd13, 0));
    send(8'h32, 0); send(8'hCD, 0); send(8'hAB, 0);
    // R9 / R10 I and R transfers
    push_ok("R9 R10 LD A,I", mk(K_REG, K_I, 3'd7, 0, 0, 0, 0, 3'd2, 5'd9, 1));
    send(8'hED, 0); send(8'h57, 0);
    push_ok("R9 R10 LD A,R", mk(K_REG, K_R, 3'd7, 0, 0, 0, 0, 3'd2, 5'd9, 1));
    send(8'hED, 0); send(8'h5F, 0);
    push_ok("R9 R10 LD I,A", mk(K_I, K_REG, 0, 3'd7, 0, 0, 0, 3'd2, 5'd9, 0));
    send(8'hED, 0); send(8'h47, 0);
    push_ok("R9 R10 LD R,A", mk(K_R, K_REG, 0, 3'd7, 0, 0, 0, 3'd2, 5'd9, 0));
    send(8'hED, 0); send(8'h4F, 0);
    // R11 illegal sequences, each followed by a fresh decode
    push_ill("R11 unprefixed 76"); send(8'h76, 0);
    push_ill("R11 unprefixed C3"); send(8'hC3, 0);
    push_ok("R11 recover LD B,C", mk(K_REG, K_REG, 3'd0, 3'd1, 0, 0, 0, 3'd1, 5'd4, 0)); send(8'h41, 0);
    push_ill("R11 DD 76"); send(8'hDD, 0); send(8'h76, 0);
    push_ill("R11 DD 41"); send(8'hDD, 0); send(8'h41, 0);
    push_ill("R11 FD 00"); send(8'hFD, 0); send(8'h00, 0);
    push_ill("R11 ED 44"); send(8'hED, 0); send(8'h44, 0);
    push_ill("R11 DD DD"); send(8'hDD, 0); send(8'hDD, 0);
    push_ok("R11 recover LD B,n", mk(K_REG, K_IMM, 3'd0, 0, 0, 8'h11, 0, 3'd2, 5'd7, 0));
    send(8'h06, 0); send(8'h11, 0);
    drain();
    // R12 gaps with garbage bytes between every byte
    push_ok("R12 gapped LD (IX+d),n", mk(K_IX, K_IMM, 0, 0, 8'hFE, 8'h42, 0, 3'd4, 5'd19, 0));
    send(8'hDD, 3); send(8'h36, 2); send(8'hFE, 4); send(8'h42, 1);
    push_ok("R12 gapped LD A,(nn)", mk(K_REG, K_DIR, 3'd7, 0, 0, 0, 16'h8001, 3'd3, 5'd13, 0));
    send(8'h3A, 2); send(8'h01, 3); send(8'h80, 0);
    drain();
    // R13 record holds while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R13 hold", !done_o && !illegal_o && actual() == last_rec,
            64'(actual()), 64'(last_rec));
    end
    check("R13 queue empty", exp_q.size() == 0, 64'(exp_q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule